// File: doc/BRIEF.md
# UART Interrupt and Break Controller

This block is the control core that sits between a UART's software control word and its serial datapath. It watches the transmit and receive buffer status, in FIFO mode the occupancy counts against programmable trigger levels, and turns it into a transmit interrupt and a receive interrupt. Each of these can be a one-clock pulse on the rising edge of its condition or a level held for as long as the condition lasts. A receive error interrupt collects the break, framing, parity and overrun flags. A receive timeout event, which only counts in FIFO mode, is merged onto the receive interrupt line.

The block also owns two serial-path controls. Loopback routes the transmitter's output into the receiver and holds the external transmit pin idle high. The send-break request drives the transmit line low for one frame time, measured in bit-tick strobes. It waits for a character already in flight to finish, and the request bit clears itself when the break ends.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After reset the control word reads back as all zero, all three interrupts are low, and `txPin` follows `txSerial`.
- R2: With control bit 0 clear (pulse type), `txIrq` is high for exactly one cycle when the transmit condition rises. The condition is `txBufEmpty` when `fifoEn` is 0, and `txCount <= txTrig` when `fifoEn` is 1.
- R3: With control bit 0 set (level type), `txIrq` equals the transmit condition in every cycle.
- R4: Control bit 1 selects pulse (0) or level (1) for the receive interrupt. The receive condition is `rxDataReady` when `fifoEn` is 0, and `rxCount >= rxTrig` when `fifoEn` is 1.
- R5: When control bit 2 is set and `fifoEn` is 1, `rxTimeout` raises `rxIrq`. It has no effect when either of the two is 0.
- R6: When control bit 3 is set, any of `errBreak`, `errFrame`, `errParity` or `errOverrun` raises `errIrq`. When bit 3 is clear, `errIrq` stays low.
- R7: When control bit 4 is set, `loopbackSel` is 1, `txPin` is held at 1, `rxCore` carries the transmitter's output and `rxPin` is ignored. When bit 4 is clear, `rxCore` equals `rxPin`.
- R8: Writing 1 to control bit 5 drives `txPin` low for exactly N bit ticks, where N = 1 + (5 + `dataBitsSel`) + `parityEn` + (`twoStop` ? 2 : 1). `dataBitsSel` values 0 to 3 select 5 to 8 data bits.
- R9: If `txBusy` is high when the break is requested, `txPin` keeps following `txSerial` until `txBusy` falls. The break starts on the following cycle.
- R10: Control bit 5 reads back 1 from the cycle after the request until the break ends, then returns to 0 by itself. Writing 0 to bit 5 during a pending or active break does not cancel it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| ctrlWe | input | 1 | Control word write strobe |
| ctrlWdata | input | 6 | Control word: [0] tx level type, [1] rx level type, [2] timeout enable, [3] error enable, [4] loopback, [5] send break |
| ctrlRdata | output | 6 | Control word readback, bit 5 is the live break state |
| dataBitsSel | input | 2 | Data bits per character minus 5 |
| parityEn | input | 1 | Parity bit present in the frame |
| twoStop | input | 1 | Two stop bits instead of one |
| fifoEn | input | 1 | FIFO mode flag |
| txCount | input | CNT_W | Transmit FIFO occupancy |
| txTrig | input | CNT_W | Transmit trigger level |
| rxCount | input | CNT_W | Receive FIFO occupancy |
| rxTrig | input | CNT_W | Receive trigger level |
| txBufEmpty | input | 1 | Non-FIFO transmit buffer empty |
| rxDataReady | input | 1 | Non-FIFO receive data present |
| errBreak | input | 1 | Break detected on receive |
| errFrame | input | 1 | Framing error |
| errParity | input | 1 | Parity error |
| errOverrun | input | 1 | Overrun error |
| rxTimeout | input | 1 | Receive timeout event |
| bitTick | input | 1 | One strobe per serial bit time |
| txBusy | input | 1 | Transmit shifter has a character in flight |
| txSerial | input | 1 | Transmit shifter output |
| rxPin | input | 1 | External receive pin |
| txIrq | output | 1 | Transmit interrupt |
| rxIrq | output | 1 | Receive interrupt, timeout included |
| errIrq | output | 1 | Receive error interrupt |
| txPin | output | 1 | External transmit pin |
| rxCore | output | 1 | Serial input to the receive shifter |
| loopbackSel | output | 1 | Loopback path selected |

## Verification
The interrupt outputs and both serial pins are combinational from the status inputs and the stored control bits. The bench therefore drives status a little after a rising edge and compares at the falling edge of the same cycle. The edge detector's history is updated at the next rising edge, so the bench model updates its previous-condition copy only after each comparison. A control write is captured on the edge after the strobe and takes effect in the cycle that follows. The break leaves the line low through the cycle holding its last bit tick and releases it at the next edge, so the bench counts the ticks that fall in low cycles and compares the total with the frame length.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
  localparam int CTRL_W   = 6;
  localparam int B_TXLVL  = 0;
  localparam int B_RXLVL  = 1;
  localparam int B_TOUT   = 2;
  localparam int B_ERR    = 3;
  localparam int B_LOOP   = 4;
  localparam int B_BRK    = 5;
  localparam int FRAME_W  = 4;

  typedef enum logic [1:0] {
    BRK_IDLE = 2'd0,
    BRK_WAIT = 2'd1,
    BRK_SEND = 2'd2
  } brkState_t;

  typedef struct packed {
    logic txLevel;
    logic rxLevel;
    logic toutEn;
    logic errEn;
    logic loopOn;
    logic breakOn;
  } ctrlStrobes_t;
endpackage

// File: rtl/uirq_edge.sv
module uirq_edge (
  input  logic clk,
  input  logic rstN,
  input  logic cond,
  input  logic levelMode,
  output logic irq
);
  logic condPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) condPrev <= 1'b0;
    else       condPrev <= cond;
  end

  assign irq = levelMode ? cond : (cond & ~condPrev);

  // R2: a pulse-type request never lasts past one cycle
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !levelMode) |=> (!irq || levelMode));
endmodule

// File: rtl/uirq_ctrl.sv
module uirq_ctrl
  import uirq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWe,
  input  logic [CTRL_W-1:0] ctrlWdata,
  input  logic [1:0]        dataBitsSel,
  input  logic              parityEn,
  input  logic              twoStop,
  input  logic              txBusy,
  input  logic              bitTick,
  output ctrlStrobes_t      strobes,
  output logic [CTRL_W-1:0] ctrlRdata
);
  logic txLevelQ, rxLevelQ, toutEnQ, errEnQ, loopOnQ;
  brkState_t brkState, brkNext;
  logic [FRAME_W-1:0] tickCnt, tickCntNext;
  logic [FRAME_W-1:0] frameLenQ, frameLenNext;
  logic [FRAME_W-1:0] frameLen;
  logic brkReq;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txLevelQ <= 1'b0;
      rxLevelQ <= 1'b0;
      toutEnQ  <= 1'b0;
      errEnQ   <= 1'b0;
      loopOnQ  <= 1'b0;
    end else if (ctrlWe) begin
      txLevelQ <= ctrlWdata[B_TXLVL];
      rxLevelQ <= ctrlWdata[B_RXLVL];
      toutEnQ  <= ctrlWdata[B_TOUT];
      errEnQ   <= ctrlWdata[B_ERR];
      loopOnQ  <= ctrlWdata[B_LOOP];
    end
  end

  // start + data + optional parity + one or two stops
  assign frameLen = FRAME_W'(7) + {2'b00, dataBitsSel}
                  + {3'b000, parityEn} + {3'b000, twoStop};
  assign brkReq   = ctrlWe && ctrlWdata[B_BRK] && (brkState == BRK_IDLE);

  always_comb begin
    brkNext      = brkState;
    tickCntNext  = tickCnt;
    frameLenNext = frameLenQ;
    unique case (brkState)
      BRK_IDLE: begin
        if (brkReq) begin
          tickCntNext  = '0;
          frameLenNext = frameLen;
          brkNext      = txBusy ? BRK_WAIT : BRK_SEND;
        end
      end
      BRK_WAIT: begin
        if (!txBusy) begin
          tickCntNext  = '0;
          frameLenNext = frameLen;
          brkNext      = BRK_SEND;
        end
      end
      BRK_SEND: begin
        if (bitTick) begin
          if (tickCnt == frameLenQ - FRAME_W'(1)) brkNext = BRK_IDLE;
          else tickCntNext = tickCnt + FRAME_W'(1);
        end
      end
      default: brkNext = BRK_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      brkState  <= BRK_IDLE;
      tickCnt   <= '0;
      frameLenQ <= '0;
    end else begin
      brkState  <= brkNext;
      tickCnt   <= tickCntNext;
      frameLenQ <= frameLenNext;
    end
  end

  assign strobes.txLevel = txLevelQ;
  assign strobes.rxLevel = rxLevelQ;
  assign strobes.toutEn  = toutEnQ;
  assign strobes.errEn   = errEnQ;
  assign strobes.loopOn  = loopOnQ;
  assign strobes.breakOn = (brkState == BRK_SEND);

  assign ctrlRdata = {(brkState != BRK_IDLE), loopOnQ, errEnQ, toutEnQ, rxLevelQ, txLevelQ};

  // R9: the break line only drops once the shifter was idle
  a_r9_break_after_char: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strobes.breakOn) |-> !$past(txBusy));
  // R8: the break only ends on a bit tick
  a_r8_break_ends_on_tick: assert property (@(posedge clk) disable iff (!rstN)
    $fell(strobes.breakOn) |-> $past(bitTick));
  // R10: a break in progress is not cancelled by a write
  a_r10_no_cancel: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.breakOn && !bitTick) |=> strobes.breakOn);
endmodule

// File: rtl/uirq_datapath.sv
module uirq_datapath
  import uirq_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobes_t     strobes,
  input  logic             fifoEn,
  input  logic [CNT_W-1:0] txCount,
  input  logic [CNT_W-1:0] txTrig,
  input  logic [CNT_W-1:0] rxCount,
  input  logic [CNT_W-1:0] rxTrig,
  input  logic             txBufEmpty,
  input  logic             rxDataReady,
  input  logic             errBreak,
  input  logic             errFrame,
  input  logic             errParity,
  input  logic             errOverrun,
  input  logic             rxTimeout,
  input  logic             txSerial,
  input  logic             rxPin,
  output logic             txIrq,
  output logic             rxIrq,
  output logic             errIrq,
  output logic             txPin,
  output logic             rxCore
);
  logic [1:0] chanCond, chanLevel, chanIrq;
  logic       txLine;
  logic       toutHit;

  assign chanCond[0]  = fifoEn ? (txCount <= txTrig) : txBufEmpty;
  assign chanCond[1]  = fifoEn ? (rxCount >= rxTrig) : rxDataReady;
  assign chanLevel[0] = strobes.txLevel;
  assign chanLevel[1] = strobes.rxLevel;

  for (genvar ch = 0; ch < 2; ch++) begin : gChan
    uirq_edge uEdge (
      .clk       (clk),
      .rstN      (rstN),
      .cond      (chanCond[ch]),
      .levelMode (chanLevel[ch]),
      .irq       (chanIrq[ch])
    );
  end

  assign toutHit = strobes.toutEn & fifoEn & rxTimeout;
  assign txIrq   = chanIrq[0];
  assign rxIrq   = chanIrq[1] | toutHit;
  assign errIrq  = strobes.errEn & (errBreak | errFrame | errParity | errOverrun);

  assign txLine  = strobes.breakOn ? 1'b0 : txSerial;
  assign txPin   = strobes.loopOn ? 1'b1 : txLine;
  assign rxCore  = strobes.loopOn ? txLine : rxPin;

  // R6: no error request without the enable from the control side
  a_r6_err_gated: assert property (@(posedge clk) disable iff (!rstN)
    errIrq |-> strobes.errEn);
  // R7: the external pin stays idle while looped back
  a_r7_loop_pin_idle: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loopOn |-> txPin);
  // R8: a break outside loopback always shows on the pin
  a_r8_break_on_pin: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.breakOn && !strobes.loopOn) |-> !txPin);
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uirq_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWe,
  input  logic [CTRL_W-1:0] ctrlWdata,
  output logic [CTRL_W-1:0] ctrlRdata,
  input  logic [1:0]        dataBitsSel,
  input  logic              parityEn,
  input  logic              twoStop,
  input  logic              fifoEn,
  input  logic [CNT_W-1:0]  txCount,
  input  logic [CNT_W-1:0]  txTrig,
  input  logic [CNT_W-1:0]  rxCount,
  input  logic [CNT_W-1:0]  rxTrig,
  input  logic              txBufEmpty,
  input  logic              rxDataReady,
  input  logic              errBreak,
  input  logic              errFrame,
  input  logic              errParity,
  input  logic              errOverrun,
  input  logic              rxTimeout,
  input  logic              bitTick,
  input  logic              txBusy,
  input  logic              txSerial,
  input  logic              rxPin,
  output logic              txIrq,
  output logic              rxIrq,
  output logic              errIrq,
  output logic              txPin,
  output logic              rxCore,
  output logic              loopbackSel
);
  ctrlStrobes_t strobes;

  uirq_ctrl uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .ctrlWe      (ctrlWe),
    .ctrlWdata   (ctrlWdata),
    .dataBitsSel (dataBitsSel),
    .parityEn    (parityEn),
    .twoStop     (twoStop),
    .txBusy      (txBusy),
    .bitTick     (bitTick),
    .strobes     (strobes),
    .ctrlRdata   (ctrlRdata)
  );

  uirq_datapath #(.CNT_W(CNT_W)) uData (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .fifoEn      (fifoEn),
    .txCount     (txCount),
    .txTrig      (txTrig),
    .rxCount     (rxCount),
    .rxTrig      (rxTrig),
    .txBufEmpty  (txBufEmpty),
    .rxDataReady (rxDataReady),
    .errBreak    (errBreak),
    .errFrame    (errFrame),
    .errParity   (errParity),
    .errOverrun  (errOverrun),
    .rxTimeout   (rxTimeout),
    .txSerial    (txSerial),
    .rxPin       (rxPin),
    .txIrq       (txIrq),
    .rxIrq       (rxIrq),
    .errIrq      (errIrq),
    .txPin       (txPin),
    .rxCore      (rxCore)
  );

  assign loopbackSel = strobes.loopOn;
endmodule

// File: tb/tb_uart_irq_ctrl.sv
module tb_uart_irq_ctrl;
  localparam int DEPTH = 16;
  localparam int CW = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ctrlWe = 1'b0;
  logic [5:0] ctrlWdata = '0;
  logic [5:0] ctrlRdata;
  logic [1:0] dataBitsSel = '0;
  logic parityEn = 0, twoStop = 0, fifoEn = 0;
  logic [CW-1:0] txCount = '0, txTrig = '0, rxCount = '0, rxTrig = '0;
  logic txBufEmpty = 0, rxDataReady = 0;
  logic errBreak = 0, errFrame = 0, errParity = 0, errOverrun = 0;
  logic rxTimeout = 0, bitTick = 0, txBusy = 0, txSerial = 1, rxPin = 1;
  logic txIrq, rxIrq, errIrq, txPin, rxCore, loopbackSel;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  int unsigned seedVal;

  always #10 clk = ~clk;

  uart_irq_ctrl #(.FIFO_DEPTH(DEPTH)) dut (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drv();
    @(posedge clk); #2;
  endtask

  task automatic writeCtrl(input logic [5:0] w);
    drv(); ctrlWe = 1; ctrlWdata = w;
    drv(); ctrlWe = 0;
  endtask

  function automatic logic txCondF(logic f, logic [CW-1:0] c, logic [CW-1:0] t, logic e);
    return f ? (c <= t) : e;
  endfunction
  function automatic logic rxCondF(logic f, logic [CW-1:0] c, logic [CW-1:0] t, logic r);
    return f ? (c >= t) : r;
  endfunction

  task automatic quiet();
    fifoEn = 0; txBufEmpty = 0; rxDataReady = 0; rxTimeout = 0;
    errBreak = 0; errFrame = 0; errParity = 0; errOverrun = 0;
  endtask

  task automatic runBreak(input logic [1:0] ds, input logic par, input logic two, input logic busy);
    int ticks = 0;
    int expLen;
    bit sawLow = 0;
    expLen = 1 + 5 + ds + par + (two ? 2 : 1);
    dataBitsSel = ds; parityEn = par; twoStop = two; txSerial = 1; txBusy = busy;
    writeCtrl(6'b100000);
    @(negedge clk);
    chk("R10 break bit set", ctrlRdata[5], 1);
    if (busy) begin
      txSerial = 0;
      repeat (3) begin
        drv(); @(negedge clk);
        chk("R9 pin follows shifter while busy", txPin, 0);
      end
      writeCtrl(6'b000000);
      @(negedge clk);
      chk("R10 write 0 does not cancel", ctrlRdata[5], 1);
      drv(); txSerial = 1; txBusy = 0;
    end
    for (int cyc = 0; cyc < 200; cyc++) begin
      drv(); bitTick = (cyc % 3 == 1);
      @(negedge clk);
      if (!txPin) begin sawLow = 1; if (bitTick) ticks++; end
      else if (sawLow) break;
    end
    bitTick = 0;
    chk("R8 break length in ticks", ticks, expLen);
    chk("R10 break bit self-cleared", ctrlRdata[5], 0);
  endtask

  initial begin
    bit prevTx, prevRx, ct, cr;
    logic [5:0] mode;
    int expRx;
    seedVal = $urandom(1234);
    repeat (3) @(posedge clk);
    #2 rstN = 1;
    @(negedge clk);
    chk("R1 ctrl reset", ctrlRdata, 0);
    chk("R1 txIrq reset", txIrq, 0);
    chk("R1 rxIrq reset", rxIrq, 0);
    chk("R1 errIrq reset", errIrq, 0);
    chk("R1 txPin follows", txPin, 1);

    // directed: pulse tx in non-FIFO mode
    drv(); txBufEmpty = 1; @(negedge clk);
    chk("R2 tx pulse first cycle", txIrq, 1);
    drv(); @(negedge clk);
    chk("R2 tx pulse gone", txIrq, 0);
    // directed: FIFO boundary count == trigger
    drv(); quiet(); fifoEn = 1; txCount = 5; txTrig = 4; rxCount = 3; rxTrig = 4;
    drv(); txCount = 4; rxCount = 4; @(negedge clk);
    chk("R2 tx pulse at trig equal", txIrq, 1);
    chk("R4 rx pulse at trig equal", rxIrq, 1);
    drv(); quiet();

    // random phase over all modes
    for (int m = 0; m < 16; m++) begin
      mode = {2'b00, m[3:0]};
      writeCtrl(mode);
      quiet();
      drv(); @(negedge clk);
      prevTx = 0; prevRx = 0;
      for (int i = 0; i < 400; i++) begin
        drv();
        fifoEn = ($urandom_range(3) != 0);
        txCount = CW'($urandom_range(DEPTH)); txTrig = CW'($urandom_range(DEPTH));
        rxCount = CW'($urandom_range(DEPTH)); rxTrig = CW'($urandom_range(DEPTH));
        txBufEmpty = ($urandom_range(2) == 0); rxDataReady = ($urandom_range(2) == 0);
        rxTimeout = ($urandom_range(4) == 0);
        errBreak = ($urandom_range(7) == 0); errFrame = ($urandom_range(7) == 0);
        errParity = ($urandom_range(7) == 0); errOverrun = ($urandom_range(7) == 0);
        @(negedge clk);
        ct = txCondF(fifoEn, txCount, txTrig, txBufEmpty);
        cr = rxCondF(fifoEn, rxCount, rxTrig, rxDataReady);
        chk(mode[0] ? "R3 tx level" : "R2 tx pulse", txIrq, mode[0] ? ct : (ct && !prevTx));
        expRx = (mode[1] ? cr : (cr && !prevRx)) || (mode[2] && fifoEn && rxTimeout);
        chk("R4 R5 rx irq", rxIrq, expRx);
        chk("R6 err irq", errIrq, mode[3] && (errBreak || errFrame || errParity || errOverrun));
        prevTx = ct; prevRx = cr;
      end
    end
    quiet();

    // directed timeout gating
    writeCtrl(6'b000100);
    drv(); fifoEn = 1; rxCount = 0; rxTrig = 8; rxTimeout = 1; @(negedge clk);
    chk("R5 timeout in FIFO mode", rxIrq, 1);
    drv(); fifoEn = 0; rxDataReady = 0; @(negedge clk);
    chk("R5 timeout ignored outside FIFO", rxIrq, 0);
    writeCtrl(6'b000000);
    drv(); fifoEn = 1; @(negedge clk);
    chk("R5 timeout disabled", rxIrq, 0);
    quiet();
    // directed error enable off
    drv(); errBreak = 1; errFrame = 1; errParity = 1; errOverrun = 1; @(negedge clk);
    chk("R6 errors with enable clear", errIrq, 0);
    quiet();

    // loopback
    writeCtrl(6'b010000);
    drv(); txSerial = 0; rxPin = 1; @(negedge clk);
    chk("R7 loopbackSel", loopbackSel, 1);
    chk("R7 pin idle high", txPin, 1);
    chk("R7 rx gets tx output", rxCore, 0);
    drv(); txSerial = 1; rxPin = 0; @(negedge clk);
    chk("R7 rx ignores pin", rxCore, 1);
    writeCtrl(6'b000000);
    drv(); txSerial = 1; rxPin = 0; @(negedge clk);
    chk("R7 normal rx path", rxCore, 0);
    chk("R7 loopbackSel clear", loopbackSel, 0);
    rxPin = 1;

    // breaks
    runBreak(2'd0, 0, 0, 0);
    runBreak(2'd3, 1, 1, 0);
    runBreak(2'd1, 0, 1, 1);
    runBreak(2'd2, 1, 0, 1);

    if (!finished) begin
      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog R1-to-R10 run act=hung exp=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule